// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block resolves interrupt requests from a row of peripheral stages wired as a priority chain. It then turns the winning stage's pointer byte into a service routine address by reading a table in memory. Each stage has an enable input and an enable output. A stage that holds a pending or in-service interrupt pulls its enable output low. Every stage further down the chain is then muted. The stage nearest the chain head always wins.

An 8-bit vector base register gives the upper byte of the table address. When the processor starts an acknowledge while the table-vectored mode is selected, the selected stage supplies its pointer byte. The block clears bit 0 of that byte and uses it as the lower byte of the table address, so the table has 128 word-aligned entries. The block reads two bytes over a simple read port, low byte first, and presents the pair as the jump target for one cycle.

The acknowledge moves the stage from pending to in-service. The stage keeps holding the chain until a return-from-interrupt pulse releases it. Only the highest-priority stage that is in service reacts to that pulse, so interrupts nest correctly.

Top module: `vic_chain`

## Requirements
- R1: After reset no stage is pending or in service, `irq_out` and `mem_rd` and `tgt_valid` are 0, the vector base is 0x00, and `chain_out` follows `chain_in`.
- R2: A stage whose request input is high for one cycle, while it is neither pending nor in service, becomes pending at that edge. `irq_out` is high in the following cycle if the stage's enable input is high.
- R3: Stage 0 is attached to `chain_in` and stage N-1 drives `chain_out`. A stage passes its enable onward only when its enable input is high and it is neither pending nor in service, so `chain_out` is low whenever any stage is pending or in service.
- R4: With `chain_in` low, a pending stage raises no `irq_out` and cannot be acknowledged. Raising `chain_in` then lets it interrupt.
- R5: An acknowledge selects the lowest-index pending stage whose enable input is high. At most one stage is selected at a time.
- R6: The table address is {vector base, pointer[7:1], 0}. The low byte of the target is read from that address and the high byte from that address plus 1, so the target is {high, low}.
- R7: When `ack_start` is accepted at edge E, `mem_rd` is high in the two cycles after E and after E+1, with the even address first. Read data is taken one cycle after each read. `tgt_valid` is high for exactly one cycle after edge E+3.
- R8: `ack_start` is ignored when `mode2_en` is low, when no stage is selected, or while a table read is in progress. In that case no read is issued and every pending stage stays pending.
- R9: An accepted acknowledge clears the selected stage's pending state and marks it in service. It keeps `chain_out` low and mutes lower-priority stages until it is released.
- R10: A `reti` pulse releases only the in-service stage whose enable input is high, that is the highest-priority one. Stages further down stay in service.
- R11: A cycle with `vbase_we` high loads `vbase_din` into the vector base, and the next acknowledge uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode2_en | input | 1 | Table-vectored interrupt mode selected |
| vbase_we | input | 1 | Load strobe for the vector base register |
| vbase_din | input | 8 | New vector base value |
| chain_in | input | 1 | Enable into the head of the chain |
| src_req | input | N_SRC | Request pulse per stage |
| src_ptr | input | 8*N_SRC | Pointer byte per stage, stage i in bits [8i+7:8i] |
| ack_start | input | 1 | Processor starts an interrupt acknowledge |
| reti | input | 1 | Return-from-interrupt indication |
| irq_out | output | 1 | Some stage is pending with its enable input high |
| chain_out | output | 1 | Enable out of the last stage |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | 16 | Table read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| tgt_valid | output | 1 | Jump target valid (one-cycle pulse) |
| tgt_addr | output | 16 | Service routine address |

## Verification
On every cycle, the assertions check these properties: at most one stage is selected, an active chain is blocked at its tail, an acknowledged stage goes from pending to in service, a released stage leaves service, the first read uses an even address with the second read one address higher, and the target pulse lasts a single cycle. Other behaviour only shows up in the bench's scenarios. These include the arithmetic of the table address against a memory pattern over every pointer and several base values, the cycle at which each read and the target appear, and the order of selection among simultaneous requests. They also include nesting and release order across several `reti` pulses, and the three cases in which an acknowledge must be ignored.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 2 * VEC_W;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_RDLO = 2'd1,
        F_RDHI = 2'd2,
        F_FIN  = 2'd3
    } fetch_st_t;

    typedef struct packed {
        logic [VEC_W-1:0] hi;
        logic [VEC_W-1:0] lo;
    } svc_addr_t;

    // Word-aligned table slot: base byte on top, pointer with bit 0 cleared below.
    function automatic logic [ADDR_W-1:0] table_addr(input logic [VEC_W-1:0] base,
                                                     input logic [VEC_W-1:0] ptr);
        return {base, ptr[VEC_W-1:1], 1'b0};
    endfunction
endpackage

// File: rtl/vic_stage.sv
module vic_stage (
    input  logic clk,
    input  logic rst,
    input  logic iei,
    input  logic req,
    input  logic ack,
    input  logic reti,
    output logic ieo,
    output logic sel,
    output logic pend_o,
    output logic insvc_o
);
    logic pend_q, insvc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            insvc_q <= 1'b0;
        end else if (ack) begin
            pend_q  <= 1'b0;
            insvc_q <= 1'b1;
        end else begin
            if (reti && iei && insvc_q)
                insvc_q <= 1'b0;
            if (req && !pend_q && !insvc_q)
                pend_q <= 1'b1;
        end
    end

    assign ieo     = iei && !pend_q && !insvc_q;
    assign sel     = iei && pend_q;
    assign pend_o  = pend_q;
    assign insvc_o = insvc_q;

    // R9: acknowledge moves the stage into service
    p_ack_to_service_r9: assert property (@(posedge clk) disable iff (rst)
        ack |=> (insvc_q && !pend_q));

    // R10: a return pulse seen with the enable high releases service
    p_reti_release_r10: assert property (@(posedge clk) disable iff (rst)
        (reti && iei && insvc_q && !ack) |=> !insvc_q);
endmodule

// File: rtl/vic_fetch.sv
module vic_fetch
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [VEC_W-1:0]  base,
    input  logic [VEC_W-1:0]  ptr,
    output logic              busy,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [VEC_W-1:0]  mem_rdata,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] tgt_addr
);
    fetch_st_t         st_q;
    logic [ADDR_W-1:0] slot_q;
    logic [VEC_W-1:0]  lo_q;
    svc_addr_t         tgt_q;
    logic              tv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= F_IDLE;
            slot_q <= '0;
            lo_q   <= '0;
            tgt_q  <= '0;
            tv_q   <= 1'b0;
        end else begin
            tv_q <= 1'b0;
            unique case (st_q)
                F_IDLE: if (go) begin
                    slot_q <= table_addr(base, ptr);
                    st_q   <= F_RDLO;
                end
                F_RDLO: st_q <= F_RDHI;
                F_RDHI: begin
                    lo_q <= mem_rdata;
                    st_q <= F_FIN;
                end
                F_FIN: begin
                    tgt_q.hi <= mem_rdata;
                    tgt_q.lo <= lo_q;
                    tv_q     <= 1'b1;
                    st_q     <= F_IDLE;
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != F_IDLE);
    assign mem_rd    = (st_q == F_RDLO) || (st_q == F_RDHI);
    assign mem_addr  = (st_q == F_RDHI) ? (slot_q | ADDR_W'(1)) : slot_q;
    assign tgt_valid = tv_q;
    assign tgt_addr  = tgt_q;

    // R7: accepted acknowledge starts the low-byte read on an even address
    p_first_read_r7: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (mem_rd && !mem_addr[0]));

    // R6: the second read follows at the next address
    p_second_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R7: target strobe lasts one cycle
    p_tgt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |=> !tgt_valid);
endmodule

// File: rtl/vic_chain.sv
module vic_chain
    import vic_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   mode2_en,
    input  logic                   vbase_we,
    input  logic [VEC_W-1:0]       vbase_din,
    input  logic                   chain_in,
    input  logic [N_SRC-1:0]       src_req,
    input  logic [N_SRC*VEC_W-1:0] src_ptr,
    input  logic                   ack_start,
    input  logic                   reti,
    output logic                   irq_out,
    output logic                   chain_out,
    output logic                   mem_rd,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [VEC_W-1:0]       mem_rdata,
    output logic                   tgt_valid,
    output logic [ADDR_W-1:0]      tgt_addr
);
    logic [N_SRC:0]   en_link;
    logic [N_SRC-1:0] sel_v, pend_v, insvc_v, ack_v;
    logic [VEC_W-1:0] vbase_q, ptr_sel;
    logic             busy, ack_go;

    always_ff @(posedge clk) begin
        if (rst)           vbase_q <= '0;
        else if (vbase_we) vbase_q <= vbase_din;
    end

    assign en_link[0] = chain_in;

    for (genvar i = 0; i < N_SRC; i++) begin : g_stage
        vic_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .iei     (en_link[i]),
            .req     (src_req[i]),
            .ack     (ack_v[i]),
            .reti    (reti),
            .ieo     (en_link[i+1]),
            .sel     (sel_v[i]),
            .pend_o  (pend_v[i]),
            .insvc_o (insvc_v[i])
        );
    end

    always_comb begin
        ptr_sel = '0;
        for (int i = 0; i < N_SRC; i++)
            if (sel_v[i]) ptr_sel |= src_ptr[i*VEC_W +: VEC_W];
    end

    assign ack_go    = ack_start && mode2_en && !busy && (|sel_v);
    assign ack_v     = ack_go ? sel_v : '0;
    assign irq_out   = |sel_v;
    assign chain_out = en_link[N_SRC];

    vic_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (ack_go),
        .base      (vbase_q),
        .ptr       (ptr_sel),
        .busy      (busy),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .tgt_valid (tgt_valid),
        .tgt_addr  (tgt_addr)
    );

    // R5: the chain leaves at most one stage selected
    p_single_sel_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_v));

    // R3: any active stage blocks the tail of the chain
    p_chain_block_r3: assert property (@(posedge clk) disable iff (rst)
        (|(pend_v | insvc_v)) |-> !chain_out);

    // R8: no acknowledge reaches a stage while a read is in flight
    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ack_v == '0));
endmodule

// File: tb/vic_chain_test.sv
module vic_chain_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode2_en = 1'b1, vbase_we = 1'b0, chain_in = 1'b1;
    logic [7:0]   vbase_din = '0;
    logic [N-1:0] src_req = '0;
    logic [8*N-1:0] src_ptr = '0;
    logic         ack_start = 1'b0, reti = 1'b0;
    logic         irq_out, chain_out, mem_rd, tgt_valid;
    logic [15:0]  mem_addr, tgt_addr;
    logic [7:0]   mem_rdata = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] cur_base = 8'h00;

    always #5 clk = ~clk;

    vic_chain #(.N_SRC(N)) uut (
        .clk(clk), .rst(rst), .mode2_en(mode2_en), .vbase_we(vbase_we),
        .vbase_din(vbase_din), .chain_in(chain_in), .src_req(src_req),
        .src_ptr(src_ptr), .ack_start(ack_start), .reti(reti),
        .irq_out(irq_out), .chain_out(chain_out), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tgt_valid(tgt_valid),
        .tgt_addr(tgt_addr)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd37;
        return t ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [15:0] exp_tgt(input logic [7:0] b, input logic [7:0] p);
        logic [15:0] a;
        a = {b, p[7:1], 1'b0};
        return {memf(a | 16'd1), memf(a)};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_base(input logic [7:0] b);
        vbase_din = b; vbase_we = 1'b1; tick();
        vbase_we = 1'b0; cur_base = b;
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        src_req = m; tick(); src_req = '0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    // Accepted acknowledge: full timing and value check (R6, R7).
    task automatic do_ack(input logic [7:0] p, input string tag);
        logic [15:0] e;
        e = exp_tgt(cur_base, p);
        ack_start = 1'b1; tick(); ack_start = 1'b0;
        chk(mem_rd && mem_addr == {cur_base, p[7:1], 1'b0}, {tag, " R7 lo read"},
            {15'd0, mem_rd, mem_addr}, {16'd1, cur_base, p[7:1], 1'b0});
        tick();
        chk(mem_rd && mem_addr == ({cur_base, p[7:1], 1'b0} | 16'd1), {tag, " R6 hi read"},
            {15'd0, mem_rd, mem_addr}, {16'd1, cur_base, p[7:1], 1'b1});
        tick();
        chk(!mem_rd && !tgt_valid, {tag, " R7 gap"}, {mem_rd, tgt_valid}, 0);
        tick();
        chk(tgt_valid && tgt_addr == e, {tag, " R6 target"}, {15'd0, tgt_valid, tgt_addr}, {16'd1, e});
        tick();
        chk(!tgt_valid, {tag, " R7 single pulse"}, tgt_valid, 0);
    endtask

    // Ignored acknowledge: no read over the following cycles (R8).
    task automatic ack_ignored(input string tag);
        bit seen;
        seen = 1'b0;
        ack_start = 1'b1; tick(); ack_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (mem_rd || tgt_valid) seen = 1'b1;
            tick();
        end
        chk(!seen, {tag, " R8 no read"}, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] bases [4];
        bases[0] = 8'h00; bases[1] = 8'h80; bases[2] = 8'hFF; bases[3] = 8'h3C;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(!irq_out && chain_out && !mem_rd && !tgt_valid, "R1 reset outputs",
            {irq_out, chain_out, mem_rd, tgt_valid}, 4'b0100);
        do begin
            src_ptr[7:0] = 8'h40;
            pulse_req(4'b0001);
            do_ack(8'h40, "R1 base zero");
            pulse_reti();
        end while (0);

        // Sweep: every pointer through each stage, several bases (R2 R3 R6 R9 R10 R11)
        for (int b = 0; b < 4; b++) begin
            set_base(bases[b]);
            for (int p = 0; p < 256; p++) begin
                int s;
                s = p % N;
                src_ptr[s*8 +: 8] = 8'(p);
                pulse_req(N'(1) << s);
                chk(irq_out && !chain_out, "R2 R3 pending raises irq, blocks chain",
                    {irq_out, chain_out}, 2'b10);
                do_ack(8'(p), "R11 sweep");
                chk(!irq_out && !chain_out, "R9 in service holds chain",
                    {irq_out, chain_out}, 2'b00);
                pulse_reti();
                chk(chain_out && !irq_out, "R10 release", {chain_out, irq_out}, 2'b10);
            end
        end

        // Priority and nesting (R5 R9 R10)
        set_base(8'h12);
        src_ptr = {8'h46, 8'h34, 8'h22, 8'h10};
        pulse_req(4'b1110);
        chk(irq_out, "R5 irq with three pending", irq_out, 1);
        do_ack(8'h22, "R5 stage1 wins");
        chk(!irq_out, "R9 lower stages muted", irq_out, 0);
        pulse_req(4'b0001);
        chk(irq_out, "R9 upper stage may nest", irq_out, 1);
        do_ack(8'h10, "R5 nested stage0");
        pulse_reti();
        chk(!chain_out && !irq_out, "R10 only stage0 released", {chain_out, irq_out}, 2'b00);
        ack_ignored("R8 nothing selected");
        pulse_reti();
        chk(irq_out, "R10 stage1 released, stage2 selectable", irq_out, 1);
        do_ack(8'h34, "R5 stage2 next");
        pulse_reti();
        do_ack(8'h46, "R5 stage3 last");
        pulse_reti();
        chk(chain_out && !irq_out, "R3 chain idle", {chain_out, irq_out}, 2'b10);

        // Mode gate (R8)
        mode2_en = 1'b0;
        pulse_req(4'b1000);
        ack_ignored("R8 mode off");
        chk(irq_out, "R8 pending kept", irq_out, 1);
        mode2_en = 1'b1;
        do_ack(8'h46, "R8 mode on");
        pulse_reti();

        // Chain head low (R4)
        chain_in = 1'b0;
        pulse_req(4'b0001);
        chk(!irq_out && !chain_out, "R4 head low mutes", {irq_out, chain_out}, 2'b00);
        ack_ignored("R4 head low");
        chain_in = 1'b1;
        tick();
        chk(irq_out, "R4 head high releases", irq_out, 1);
        do_ack(8'h10, "R4 after head high");
        pulse_reti();

        // Acknowledge during a read is ignored (R8)
        pulse_req(4'b0100);
        ack_start = 1'b1; tick();
        ack_start = 1'b0; src_req = 4'b0001; tick();
        src_req = '0; ack_start = 1'b1; tick();
        ack_start = 1'b0; tick();
        chk(tgt_valid && tgt_addr == exp_tgt(8'h12, 8'h34), "R8 busy target unchanged",
            tgt_addr, exp_tgt(8'h12, 8'h34));
        tick();
        chk(!mem_rd && irq_out, "R8 busy ack left stage0 pending", {mem_rd, irq_out}, 2'b01);
        do_ack(8'h10, "R8 stage0 later");
        pulse_reti();
        chk(!chain_out, "R10 stage2 still in service", chain_out, 0);
        pulse_reti();
        chk(chain_out && !irq_out, "R10 all released", {chain_out, irq_out}, 2'b10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule